// File: doc/BRIEF.md
# Data-Processing Second-Operand Shifter

This block forms the second operand of a data-processing instruction and the carry that the shifter produces. It takes the 32-bit instruction word, the value of the operand register, the low byte of the shift-amount register and the current carry flag. From these it yields either an 8-bit constant rotated right by an even amount, or the operand register shifted by one of four shift kinds. The shift amount comes either from a 5-bit immediate field or from the register byte. A second mode forms the index offset of a load/store address. That mode honours immediate amounts only.

The shifter logic is combinational and has one output register behind it. Operands enter and results leave through valid/ready handshakes. A transfer happens on a clock edge where both valid and ready are high. The block accepts a new operand set when its output slot is empty, or when the slot is being drained in the same cycle (`in_ready = !out_valid || out_ready`). A result that is not taken stays on the outputs unchanged until `out_ready` is high. Back-pressure from the output therefore reaches the input with no added cycle and no skid storage. The flag logic and the ALU downstream are outside this block.

Top module: `shop_unit`

## Requirements
- R1: While `rst_n` is low, and after it, until the first accepted operand set, `out_valid` is 0. `in_ready` is 1 whenever `out_valid` is 0.
- R2: An operand set accepted on an edge (`in_valid && in_ready`) appears on `out_operand`/`out_carry` with `out_valid` high after that edge. A result that is not taken holds steady. `in_ready` equals `!out_valid || out_ready`. Results leave in the order they were accepted.
- R3: Immediate form, selected when instruction bit 25 is 1 and `in_index_mode` is 0. The operand is the 8-bit value from bits [7:0], rotated right by twice the 4-bit value in bits [11:8]. The carry is `in_carry` when that rotation is zero. Otherwise the carry is operand bit 31.
- R4: LSL, selected by bits [6:5]=00. Let n be the amount: bits [11:7] when bit 4 is 0, `in_rs_lo` when bit 4 is 1. For n from 1 to 31 the result is Rm<<n and the carry is Rm bit (32−n). A register amount of 32 gives 0 with carry Rm bit 0. A register amount above 32 gives 0 with carry 0.
- R5: LSR (bits [6:5]=01). An immediate 0 means a shift by 32: result 0, carry Rm bit 31. For n from 1 to 31 the result is Rm>>n and the carry is Rm bit (n−1). A register amount of 32 gives 0 with carry Rm bit 31. A register amount above 32 gives 0 with carry 0.
- R6: ASR (bits [6:5]=10). An immediate 0, or a register amount of 32 or more, fills every result bit with Rm bit 31 and sets the carry to Rm bit 31. For n from 1 to 31 the result is an arithmetic right shift and the carry is Rm bit (n−1).
- R7: ROR (bits [6:5]=11). An immediate 0 gives rotate-with-extend: {carry, Rm[31:1]}, with carry out Rm bit 0. A nonzero amount m = n mod 32 rotates Rm right by m, with carry Rm bit (m−1). A nonzero register amount with m = 0 gives Rm unchanged with carry Rm bit 31.
- R8: A register-specified amount of 0 (`in_rs_lo` = 0 with bit 4 = 1) gives Rm unchanged with carry equal to `in_carry`. This holds for all four kinds. An immediate LSL by 0 behaves the same way.
- R9: With `in_index_mode` = 1, bits 25 and 4 are ignored. The shift always uses the immediate amount in bits [11:7], with the immediate-amount rules of R4 to R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operand set present |
| in_ready | output | 1 | Block can take an operand set |
| in_instr | input | 32 | Instruction word |
| in_rm | input | 32 | Value of the shifted operand register |
| in_rs_lo | input | 8 | Low byte of the shift-amount register |
| in_carry | input | 1 | Current carry flag |
| in_index_mode | input | 1 | 1: form a load/store index offset (immediate amounts only) |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_operand | output | 32 | Shifted or rotated operand |
| out_carry | output | 1 | Shifter carry-out |

## Verification
Each result is due exactly one edge after the edge that accepted its operands. It stays due on every later edge until an edge where `out_ready` is high. The bench drives inputs and samples outputs at the falling edge. It settles each handshake one nanosecond after driving, and only then moves its queue of expected results. The result present at each falling edge is therefore compared with the head of that queue on every cycle. Random stalls on both sides cover the cases where a result must be held and where a result is drained and replaced on the same edge.

// File: rtl/shop_pkg.sv
package shop_pkg;
  typedef enum logic [1:0] {
    SK_LSL = 2'b00,
    SK_LSR = 2'b01,
    SK_ASR = 2'b10,
    SK_ROR = 2'b11
  } shift_kind_e;

  typedef struct packed {
    shift_kind_e kind;
    logic [7:0]  amount;
    logic        rrx;
  } shift_req_t;
endpackage

// File: rtl/shop_amount_sel.sv
module shop_amount_sel
  import shop_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [7:0]  sh_field,
  input  logic [7:0]  rs_lo,
  input  logic        index_mode,
  output shift_req_t  req
);
  localparam logic [7:0] FULL_AMT = 8'(DATA_W);

  logic       by_reg;
  logic [4:0] imm5;

  assign by_reg = sh_field[0] & ~index_mode;
  assign imm5   = sh_field[7:3];

  always_comb begin
    req.kind   = shift_kind_e'(sh_field[2:1]);
    req.rrx    = 1'b0;
    req.amount = 8'd0;
    if (by_reg) begin
      req.amount = rs_lo;
    end else begin
      unique case (shift_kind_e'(sh_field[2:1]))
        SK_LSL: req.amount = {3'b000, imm5};
        SK_LSR, SK_ASR:
          req.amount = (imm5 == 5'd0) ? FULL_AMT : {3'b000, imm5};
        SK_ROR: begin
          req.rrx    = (imm5 == 5'd0);
          req.amount = {3'b000, imm5};
        end
        default: req.amount = 8'd0;
      endcase
    end
  end
endmodule

// File: rtl/shop_shift_core.sv
module shop_shift_core
  import shop_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  shift_req_t        req,
  input  logic [DATA_W-1:0] rm,
  input  logic              c_in,
  output logic [DATA_W-1:0] res,
  output logic              c_out
);
  localparam int         SH_W     = $clog2(DATA_W);
  localparam logic [7:0] FULL_AMT = 8'(DATA_W);

  logic [2*DATA_W-1:0]  lsl_ext;
  logic [DATA_W:0]      lsr_ext;
  logic signed [DATA_W:0] asr_ext;
  logic [7:0]           asr_amt;
  logic [SH_W-1:0]      rot_amt;
  logic [2*DATA_W-1:0]  rot_ext;
  logic [DATA_W-1:0]    rot_res;
  logic                 amt_zero;
  logic                 amt_over;

  assign amt_zero = (req.amount == 8'd0);
  assign amt_over = (req.amount > FULL_AMT);
  assign lsl_ext  = {{DATA_W{1'b0}}, rm} << req.amount;
  assign lsr_ext  = {rm, 1'b0} >> req.amount;
  assign asr_amt  = (req.amount >= FULL_AMT) ? FULL_AMT : req.amount;
  assign asr_ext  = $signed({rm, 1'b0}) >>> asr_amt;
  assign rot_amt  = req.amount[SH_W-1:0];
  assign rot_ext  = {rm, rm} >> rot_amt;
  assign rot_res  = rot_ext[DATA_W-1:0];

  always_comb begin
    res   = rm;
    c_out = c_in;
    unique case (req.kind)
      SK_LSL: begin
        if (amt_over) begin
          res = '0; c_out = 1'b0;
        end else if (!amt_zero) begin
          res = lsl_ext[DATA_W-1:0]; c_out = lsl_ext[DATA_W];
        end
      end
      SK_LSR: begin
        if (amt_over) begin
          res = '0; c_out = 1'b0;
        end else if (!amt_zero) begin
          res = lsr_ext[DATA_W:1]; c_out = lsr_ext[0];
        end
      end
      SK_ASR: begin
        if (!amt_zero) begin
          res = asr_ext[DATA_W:1]; c_out = asr_ext[0];
        end
      end
      SK_ROR: begin
        if (req.rrx) begin
          res = {c_in, rm[DATA_W-1:1]}; c_out = rm[0];
        end else if (!amt_zero) begin
          res = rot_res; c_out = rot_res[DATA_W-1];
        end
      end
      default: begin
        res = rm; c_out = c_in;
      end
    endcase
  end

  always_comb begin
    // R4
    if (req.kind == SK_LSL && amt_over)
      lsl_far_chk: assert (res == '0 && !c_out);
    // R6
    if (req.kind == SK_ASR && req.amount >= FULL_AMT)
      asr_fill_chk: assert (res == {DATA_W{rm[DATA_W-1]}} && c_out == rm[DATA_W-1]);
    // R7
    if (req.rrx)
      rrx_ins_chk: assert (res[DATA_W-1] == c_in && c_out == rm[0]);
    // R8
    if (amt_zero && !req.rrx)
      zero_amt_chk: assert (res == rm && c_out == c_in);
  end
endmodule

// File: rtl/shop_imm_rot.sv
module shop_imm_rot #(
  parameter int DATA_W = 32
) (
  input  logic [7:0]        imm8,
  input  logic [3:0]        rot4,
  input  logic              c_in,
  output logic [DATA_W-1:0] res,
  output logic              c_out
);
  localparam int SH_W = $clog2(DATA_W);

  logic [DATA_W-1:0]   imm_w;
  logic [SH_W-1:0]     rot_amt;
  logic [2*DATA_W-1:0] rot_ext;

  assign imm_w   = {{(DATA_W-8){1'b0}}, imm8};
  assign rot_amt = SH_W'({rot4, 1'b0});
  assign rot_ext = {imm_w, imm_w} >> rot_amt;
  assign res     = rot_ext[DATA_W-1:0];
  assign c_out   = (rot4 == 4'd0) ? c_in : rot_ext[DATA_W-1];

  always_comb begin
    // R3
    if (rot4 == 4'd0)
      imm_plain_chk: assert (res == imm_w && c_out == c_in);
  end
endmodule

// File: rtl/shop_out_reg.sv
module shop_out_reg #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] d_op,
  input  logic              d_c,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] q_op,
  output logic              q_c
);
  assign in_ready = ~out_valid | out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      q_op      <= '0;
      q_c       <= 1'b0;
    end else begin
      if (in_ready) out_valid <= in_valid;
      if (in_valid && in_ready) begin
        q_op <= d_op;
        q_c  <= d_c;
      end
    end
  end

  // R1
  rst_empty_chk: assert property (@(posedge clk) !rst_n |=> !out_valid);
  // R2
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(q_op) && $stable(q_c));
  // R2
  accept_show_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);
endmodule

// File: rtl/shop_unit.sv
module shop_unit
  import shop_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [31:0]       in_instr,
  input  logic [DATA_W-1:0] in_rm,
  input  logic [7:0]        in_rs_lo,
  input  logic              in_carry,
  input  logic              in_index_mode,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_operand,
  output logic              out_carry
);
  shift_req_t        req;
  logic [DATA_W-1:0] sh_res, imm_res, sel_res;
  logic              sh_c, imm_c, sel_c, use_imm;
  logic              unused_bits;

  assign unused_bits = ^{in_instr[31:26], in_instr[24:12]};
  assign use_imm     = in_instr[25] & ~in_index_mode;

  shop_amount_sel #(.DATA_W(DATA_W)) i_amt (
    .sh_field(in_instr[11:4]), .rs_lo(in_rs_lo),
    .index_mode(in_index_mode), .req(req)
  );

  shop_shift_core #(.DATA_W(DATA_W)) i_core (
    .req(req), .rm(in_rm), .c_in(in_carry), .res(sh_res), .c_out(sh_c)
  );

  shop_imm_rot #(.DATA_W(DATA_W)) i_rot (
    .imm8(in_instr[7:0]), .rot4(in_instr[11:8]), .c_in(in_carry),
    .res(imm_res), .c_out(imm_c)
  );

  assign sel_res = use_imm ? imm_res : sh_res;
  assign sel_c   = use_imm ? imm_c : sh_c;

  shop_out_reg #(.DATA_W(DATA_W)) i_out (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .d_op(sel_res), .d_c(sel_c), .out_valid(out_valid),
    .out_ready(out_ready), .q_op(out_operand), .q_c(out_carry)
  );
endmodule

// File: tb/test_shop_unit.sv
module test_shop_unit;
  typedef struct {
    logic [31:0] ir;
    logic [31:0] rm;
    logic [7:0]  rs;
    logic        c;
    logic        idx;
  } stim_t;

  typedef struct {
    logic [31:0] op;
    logic        c;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_instr = '0;
  logic [31:0] in_rm = '0;
  logic [7:0]  in_rs_lo = '0;
  logic        in_carry = 1'b0;
  logic        in_index_mode = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [31:0] out_operand;
  logic        out_carry;

  int total = 0;
  int bad = 0;
  stim_t stim_q[$];
  exp_t  exp_q[$];

  always #4 clk = ~clk;

  shop_unit i_shop_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_instr(in_instr), .in_rm(in_rm), .in_rs_lo(in_rs_lo),
    .in_carry(in_carry), .in_index_mode(in_index_mode),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_operand(out_operand), .out_carry(out_carry)
  );

  function automatic void model(input stim_t s, output logic [31:0] r, output logic co);
    int n, k, m;
    logic byreg;
    logic [31:0] v;
    if (s.ir[25] && !s.idx) begin
      n = 2 * int'(s.ir[11:8]);
      v = {24'd0, s.ir[7:0]};
      r = (n == 0) ? v : ((v >> n) | (v << (32 - n)));
      co = (n == 0) ? s.c : r[31];
      return;
    end
    k = int'(s.ir[6:5]);
    byreg = s.ir[4] && !s.idx;
    n = byreg ? int'(s.rs) : int'(s.ir[11:7]);
    r = s.rm; co = s.c;
    if (!byreg) begin
      case (k)
        0: if (n != 0) begin r = s.rm << n; co = s.rm[32-n]; end
        1: if (n == 0) begin r = 0; co = s.rm[31]; end
           else begin r = s.rm >> n; co = s.rm[n-1]; end
        2: if (n == 0) begin r = {32{s.rm[31]}}; co = s.rm[31]; end
           else begin r = $signed(s.rm) >>> n; co = s.rm[n-1]; end
        default: if (n == 0) begin r = {s.c, s.rm[31:1]}; co = s.rm[0]; end
           else begin r = (s.rm >> n) | (s.rm << (32 - n)); co = s.rm[n-1]; end
      endcase
    end else if (n != 0) begin
      case (k)
        0: if (n < 32) begin r = s.rm << n; co = s.rm[32-n]; end
           else if (n == 32) begin r = 0; co = s.rm[0]; end
           else begin r = 0; co = 1'b0; end
        1: if (n < 32) begin r = s.rm >> n; co = s.rm[n-1]; end
           else if (n == 32) begin r = 0; co = s.rm[31]; end
           else begin r = 0; co = 1'b0; end
        2: if (n < 32) begin r = $signed(s.rm) >>> n; co = s.rm[n-1]; end
           else begin r = {32{s.rm[31]}}; co = s.rm[31]; end
        default: begin
          m = n % 32;
          if (m == 0) begin r = s.rm; co = s.rm[31]; end
          else begin r = (s.rm >> m) | (s.rm << (32 - m)); co = s.rm[m-1]; end
        end
      endcase
    end
  endfunction

  function automatic string tag_of(input stim_t s);
    if (s.ir[25] && !s.idx) return "R3";
    if (s.idx) return "R9";
    if (s.ir[4] && s.rs == 8'd0) return "R8";
    case (s.ir[6:5])
      2'b00: return "R4";
      2'b01: return "R5";
      2'b10: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic add(input logic [31:0] ir, input logic [7:0] rs, input logic idx);
    stim_t s;
    logic [31:0] pats[3];
    pats[0] = 32'h8000_0001; pats[1] = 32'h7FFF_FFFE; pats[2] = $urandom;
    foreach (pats[p]) begin
      for (int c = 0; c < 2; c++) begin
        s.ir = ir; s.rm = pats[p]; s.rs = rs; s.c = c[0]; s.idx = idx;
        stim_q.push_back(s);
      end
    end
  endtask

  task automatic chk(input bit ok, input string tag, input logic [32:0] act, input logic [32:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin
    int cyc;
    logic [7:0] ramt[7];
    ramt[0] = 0; ramt[1] = 1; ramt[2] = 31; ramt[3] = 32;
    ramt[4] = 33; ramt[5] = 64; ramt[6] = 255;

    for (int k = 0; k < 4; k++) begin
      add(32'hE1A0_0000 | (32'(k) << 5), 8'd0, 1'b0);
      add(32'hE1A0_0000 | (32'd1 << 7) | (32'(k) << 5), 8'd0, 1'b0);
      add(32'hE1A0_0000 | (32'd31 << 7) | (32'(k) << 5), 8'd0, 1'b0);
      foreach (ramt[a]) add(32'hE1A0_0010 | (32'(k) << 5), ramt[a], 1'b0);
      add(32'hE790_0010 | (32'(k) << 5), 8'd7, 1'b1);
      add(32'hE790_0000 | (32'd1 << 7) | (32'(k) << 5), 8'd0, 1'b1);
      add(32'hE790_0010 | (32'd31 << 7) | (32'(k) << 5), 8'd40, 1'b1);
      add(32'hE7B0_0000 | (32'd17 << 7) | (32'(k) << 5), 8'd3, 1'b1);
    end
    add(32'hE3A0_00A5, 8'd0, 1'b0);
    add(32'hE3A0_01A5, 8'd0, 1'b0);
    add(32'hE3A0_0481, 8'd0, 1'b0);
    add(32'hE3A0_0F81, 8'd0, 1'b0);

    repeat (3) begin
      @(negedge clk);
      // R1
      chk(out_valid == 1'b0 && in_ready == 1'b1, "R1", {31'd0, out_valid, in_ready}, 33'd1);
    end
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(out_valid == 1'b0, "R1", {32'd0, out_valid}, 33'd0);

    cyc = 0;
    while (stim_q.size() > 0 || exp_q.size() > 0) begin
      @(negedge clk);
      cyc++;
      if (cyc > 20000) begin
        chk(1'b0, "watchdog", 33'd0, 33'd1);
        break;
      end
      // R2: presence of a result matches the model queue
      chk(out_valid == (exp_q.size() > 0), "R2", {32'd0, out_valid}, {32'd0, exp_q.size() > 0});
      if (out_valid && exp_q.size() > 0)
        chk(out_operand == exp_q[0].op && out_carry == exp_q[0].c, exp_q[0].tag,
            {out_carry, out_operand}, {exp_q[0].c, exp_q[0].op});
      in_valid = (stim_q.size() > 0) && ($urandom % 4 != 0);
      if (stim_q.size() > 0) begin
        in_instr = stim_q[0].ir; in_rm = stim_q[0].rm; in_rs_lo = stim_q[0].rs;
        in_carry = stim_q[0].c; in_index_mode = stim_q[0].idx;
      end
      out_ready = ($urandom % 3 != 0);
      #1;
      // R2
      chk(in_ready == (!out_valid || out_ready), "R2", {32'd0, in_ready}, {32'd0, !out_valid || out_ready});
      if (out_valid && out_ready && exp_q.size() > 0) void'(exp_q.pop_front());
      if (in_valid && in_ready) begin
        exp_t e;
        stim_t s;
        s = stim_q.pop_front();
        model(s, e.op, e.c);
        e.tag = tag_of(s);
        exp_q.push_back(e);
      end
    end
    in_valid = 1'b0;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule